// File: doc/BRIEF.md
# Clock Mode Select Controller

This block holds the control register and sequencer that choose which clock drives a chip: the main oscillator, a low-speed sub oscillator, or a PLL derived from the main oscillator. Software writes one 16-bit register. Two request bits pick the source, a two-bit field sets the PLL multiplier, and a two-bit field sets how many oscillator cycles to wait for the PLL to settle. Two read-only status bits in the same register report which source is actually running. These bits change only once the sequencer has finished the switch.

When the PLL is requested, the sequencer first counts the programmed number of oscillator cycles. During the count it holds a busy output high and keeps the main clock selected. When the count ends, it moves the select code to the PLL. The longest wait code gives a longer count when the last reset was a power-on reset. A switch to the sub clock or back to the main clock takes one cycle. The select code and the multiplier code drive an external glitch-free clock multiplexer and the PLL, and neither of those is part of this block.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the register reads 0xFC00, `clk_sel` is 00 (main), `mult_code` is 00 and `busy` is 0.
- R2: Bit 15 reads 0 only while the sub clock runs (`clk_sel` = 01). Bit 14 reads 0 only while the PLL runs (`clk_sel` = 10). Otherwise each reads 1.
- R3: Writes to bits 15, 14 and 7:0 have no effect. Bits 7:0 always read 0.
- R4: Bit 11 written 0 requests the sub clock and takes priority over bit 10. One cycle after the write, `clk_sel` is 01, with no wait and `busy` low.
- R5: Bit 10 written 0, with bit 11 at 1, starts a stabilization wait on the next cycle. `busy` stays high for exactly the wait length and `clk_sel` stays 00 during it. On the cycle `busy` falls, `clk_sel` becomes 10 and bit 14 reads 0.
- R6: Wait field bits 13:12 set the wait length: 00 gives 1024 cycles, 01 gives 8192 and 10 gives 16384.
- R7: Wait code 11 gives 32768 cycles when `por_rst` is 0 and 65536 cycles when `por_rst` is 1.
- R8: Bits 9:8 (multiplier, 00 = x1 up to 11 = x4) drive `mult_code` and are written only while no PLL wait or PLL operation is in progress. Writes during either of those leave the field unchanged.
- R9: Writing bits 11 and 10 both to 1 returns to the main clock one cycle later, from the PLL or from the sub clock. Doing this during a wait cancels it and drops `busy`. The PLL can also be left directly for the sub clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, also the wait count clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| por_rst | input | 1 | 1 when the most recent reset was a power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read value, status bits included |
| clk_sel | output | 2 | Source select: 00 main, 01 sub, 10 PLL |
| mult_code | output | 2 | PLL multiplier code |
| busy | output | 1 | High while a stabilization wait is counting |

## Verification
The assertions assume that `por_rst` is stable across each wait and that the oscillator clock is the only clock. They also assume that software writes one whole register value per strobe, so the request bits, wait field and multiplier change on the same edge. The directed stimulus changes `por_rst` only while the main clock runs. It issues each write as a single-cycle strobe away from the clock edge and leaves at least one idle cycle between writes, so every status change can be sampled in a known cycle.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

  typedef enum logic [1:0] {
    ST_MAIN     = 2'b00,
    ST_SUB      = 2'b01,
    ST_PLL_WAIT = 2'b10,
    ST_PLL      = 2'b11
  } clk_state_e;

  localparam logic [1:0] SEL_MAIN = 2'b00;
  localparam logic [1:0] SEL_SUB  = 2'b01;
  localparam logic [1:0] SEL_PLL  = 2'b10;

  typedef struct packed {
    logic [1:0] wait_code;
    logic       sub_req_n;
    logic       pll_req_n;
    logic [1:0] mult;
  } clk_ctl_t;

endpackage

// File: rtl/clkmode_regs.sv
module clkmode_regs
  import clkmode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  clk_ctl_t wr_ctl,
  input  logic     pll_engaged,
  output clk_ctl_t ctl
);

  clk_ctl_t ctl_nxt;
  logic     ctl_en;

  assign ctl_en = wr_en;

  always_comb begin
    ctl_nxt           = ctl;
    ctl_nxt.wait_code = wr_ctl.wait_code;
    ctl_nxt.sub_req_n = wr_ctl.sub_req_n;
    ctl_nxt.pll_req_n = wr_ctl.pll_req_n;
    if (!pll_engaged) begin
      ctl_nxt.mult = wr_ctl.mult;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl.wait_code <= 2'b11;
      ctl.sub_req_n <= 1'b1;
      ctl.pll_req_n <= 1'b1;
      ctl.mult      <= 2'b00;
    end else if (ctl_en) begin
      ctl <= ctl_nxt;
    end
  end

endmodule

// File: rtl/clkmode_wait_cnt.sv
module clkmode_wait_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  assign zero   = (cnt == '0);
  assign cnt_en = load | (run & ~zero);

  always_comb begin
    if (load) cnt_nxt = load_val;
    else      cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

endmodule

// File: rtl/clkmode_seq.sv
module clkmode_seq
  import clkmode_pkg::*;
#(
  parameter int EXP_C0  = 10,
  parameter int EXP_C1  = 13,
  parameter int EXP_C2  = 14,
  parameter int EXP_C3  = 15,
  parameter int EXP_POR = 16,
  parameter int CNT_W   = EXP_POR
) (
  input  logic       clk,
  input  logic       rst_n,
  input  clk_ctl_t   ctl,
  input  logic       por_rst,
  input  logic       cnt_zero,
  output logic       cnt_load,
  output logic [CNT_W-1:0] cnt_load_val,
  output logic       cnt_run,
  output clk_state_e state
);

  localparam logic [CNT_W-1:0] LD_C0  = CNT_W'((64'd1 << EXP_C0) - 64'd1);
  localparam logic [CNT_W-1:0] LD_C1  = CNT_W'((64'd1 << EXP_C1) - 64'd1);
  localparam logic [CNT_W-1:0] LD_C2  = CNT_W'((64'd1 << EXP_C2) - 64'd1);
  localparam logic [CNT_W-1:0] LD_C3  = CNT_W'((64'd1 << EXP_C3) - 64'd1);
  localparam logic [CNT_W-1:0] LD_POR = CNT_W'((64'd1 << EXP_POR) - 64'd1);

  clk_state_e state_nxt;
  clk_state_e target;

  // Sub request wins over PLL request.
  always_comb begin
    if (!ctl.sub_req_n)      target = ST_SUB;
    else if (!ctl.pll_req_n) target = ST_PLL;
    else                     target = ST_MAIN;
  end

  always_comb begin
    unique case (ctl.wait_code)
      2'b00:   cnt_load_val = LD_C0;
      2'b01:   cnt_load_val = LD_C1;
      2'b10:   cnt_load_val = LD_C2;
      default: cnt_load_val = por_rst ? LD_POR : LD_C3;
    endcase
  end

  assign cnt_load = (state == ST_MAIN) && (target == ST_PLL);
  assign cnt_run  = (state == ST_PLL_WAIT);

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_MAIN: begin
        if (target == ST_SUB)      state_nxt = ST_SUB;
        else if (target == ST_PLL) state_nxt = ST_PLL_WAIT;
      end
      ST_SUB: begin
        if (target != ST_SUB) state_nxt = ST_MAIN;
      end
      ST_PLL_WAIT: begin
        if (target != ST_PLL) state_nxt = target;
        else if (cnt_zero)    state_nxt = ST_PLL;
      end
      default: begin
        if (target != ST_PLL) state_nxt = target;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_MAIN;
    else        state <= state_nxt;
  end

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int EXP_C0  = 10,
  parameter int EXP_C1  = 13,
  parameter int EXP_C2  = 14,
  parameter int EXP_C3  = 15,
  parameter int EXP_POR = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_rst,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic [1:0]  clk_sel,
  output logic [1:0]  mult_code,
  output logic        busy
);

  localparam int CNT_W = EXP_POR;

  clk_ctl_t         ctl;
  clk_ctl_t         wr_ctl;
  clk_state_e       state;
  logic             cnt_load;
  logic             cnt_run;
  logic             cnt_zero;
  logic [CNT_W-1:0] cnt_load_val;
  logic             pll_engaged;
  logic             unused_wr_bits;

  assign wr_ctl         = clk_ctl_t'(wr_data[13:8]);
  assign unused_wr_bits = ^{wr_data[15:14], wr_data[7:0]};
  assign pll_engaged    = (state == ST_PLL_WAIT) || (state == ST_PLL);

  clkmode_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_ctl      (wr_ctl),
    .pll_engaged (pll_engaged),
    .ctl         (ctl)
  );

  clkmode_seq #(
    .EXP_C0  (EXP_C0),
    .EXP_C1  (EXP_C1),
    .EXP_C2  (EXP_C2),
    .EXP_C3  (EXP_C3),
    .EXP_POR (EXP_POR),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl          (ctl),
    .por_rst      (por_rst),
    .cnt_zero     (cnt_zero),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .cnt_run      (cnt_run),
    .state        (state)
  );

  clkmode_wait_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .run      (cnt_run),
    .zero     (cnt_zero)
  );

  always_comb begin
    unique case (state)
      ST_SUB:  clk_sel = SEL_SUB;
      ST_PLL:  clk_sel = SEL_PLL;
      default: clk_sel = SEL_MAIN;
    endcase
  end

  assign busy      = (state == ST_PLL_WAIT);
  assign mult_code = ctl.mult;
  assign rd_data   = {(state != ST_SUB), (state != ST_PLL), ctl, 8'h00};

endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_nsub,
  input logic       stat_npll,
  input logic       sub_req_n,
  input logic [1:0] clk_sel,
  input logic [1:0] mult_code,
  input logic       busy
);

  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_nsub || stat_npll)) else $error("status bits both low"); // R2

  AST_SUB_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_req_n |=> (clk_sel == 2'b01)) else $error("sub request not honoured"); // R4

  AST_BUSY_ON_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (clk_sel == 2'b00 && stat_npll)) else $error("wait not on main clock"); // R5

  AST_PLL_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel == 2'b10) |-> $past(busy)) else $error("PLL entered without wait"); // R5

  AST_MULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b10 || busy) |=> $stable(mult_code)) else $error("multiplier changed"); // R8

endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stat_nsub (rd_data[15]),
  .stat_npll (rd_data[14]),
  .sub_req_n (rd_data[11]),
  .clk_sel   (clk_sel),
  .mult_code (mult_code),
  .busy      (busy)
);

// File: tb/test_clkmode_ctrl.sv
module test_clkmode_ctrl;

  logic        clk;
  logic        rst_n;
  logic        por_rst;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [1:0]  clk_sel;
  logic [1:0]  mult_code;
  logic        busy;

  int checks;
  int failures;
  int cycles;

  clkmode_ctrl i_clkmode_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_rst   (por_rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .clk_sel   (clk_sel),
    .mult_code (mult_code),
    .busy      (busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Register image: [13:12] wait, [11] sub_n, [10] pll_n, [9:8] mult
  function automatic logic [15:0] img(input logic [1:0] ws, input logic sn,
                                      input logic pn, input logic [1:0] ml);
    return {2'b00, ws, sn, pn, ml, 8'h00};
  endfunction

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
    end
  endtask

  task automatic do_write(input logic [15:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = 16'h0;
  endtask

  task automatic go_main();
    do_write(img(2'b00, 1'b1, 1'b1, 2'b00));
    @(negedge clk);
  endtask

  // Returns number of cycles busy is high, ends on negedge after busy falls.
  task automatic run_wait(input logic [1:0] ws, input logic [1:0] ml, output int n);
    do_write(img(ws, 1'b1, 1'b0, ml));
    n = 0;
    @(negedge clk);
    while (busy && n < 70000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 16'hFC00);
    chk("R1 clk_sel", clk_sel, 0);
    chk("R1 mult_code", mult_code, 0);
    chk("R1 busy", busy, 0);
  endtask

  task automatic t_readonly();
    do_write(16'h3CFF & 16'hFFFF);   // bits 15:14 = 0, low byte ones
    @(negedge clk);
    chk("R3 status bits unchanged", rd_data[15:14], 2'b11);
    chk("R3 low byte reads zero", rd_data[7:0], 0);
    chk("R3 sel stays main", clk_sel, 0);
    go_main();
  endtask

  task automatic t_sub_priority();
    do_write(img(2'b00, 1'b0, 1'b0, 2'b00));
    @(negedge clk);
    chk("R4 clk_sel sub", clk_sel, 1);
    chk("R4 busy low", busy, 0);
    chk("R2 bit15 low on sub", rd_data[15], 0);
    chk("R2 bit14 high on sub", rd_data[14], 1);
    do_write(img(2'b00, 1'b1, 1'b1, 2'b00));
    chk("R9 still sub before edge", clk_sel, 1);
    @(negedge clk);
    chk("R9 sub to main", clk_sel, 0);
    chk("R9 status after sub", rd_data[15:14], 2'b11);
  endtask

  task automatic t_wait(input logic [1:0] ws, input logic por, input int exp_n, input string req);
    int n;
    por_rst = por;
    run_wait(ws, 2'b00, n);
    chk(req, n, exp_n);
    chk("R5 clk_sel pll after wait", clk_sel, 2);
    chk("R2 bit14 low on pll", rd_data[14], 0);
    go_main();
    chk("R9 pll to main", clk_sel, 0);
    por_rst = 1'b0;
  endtask

  task automatic t_mult_lock();
    int n;
    do_write(img(2'b00, 1'b1, 1'b1, 2'b10));
    chk("R8 mult written on main", mult_code, 2);
    chk("R8 mult read back", rd_data[9:8], 2);
    // Request PLL and set x4 in the same write (accepted: main at write edge).
    do_write(img(2'b00, 1'b1, 1'b0, 2'b11));
    chk("R8 mult set with request", mult_code, 3);
    repeat (5) @(negedge clk);
    chk("R5 busy during wait", busy, 1);
    chk("R5 clk_sel main during wait", clk_sel, 0);
    do_write(img(2'b00, 1'b1, 1'b0, 2'b01));
    chk("R8 write ignored in wait", mult_code, 3);
    n = 0;
    while (busy && n < 2000) begin
      n++;
      @(negedge clk);
    end
    chk("R5 reached pll", clk_sel, 2);
    do_write(img(2'b00, 1'b1, 1'b0, 2'b00));
    @(negedge clk);
    chk("R8 write ignored on pll", mult_code, 3);
    chk("R8 still pll", clk_sel, 2);
    // PLL directly to sub
    do_write(img(2'b00, 1'b0, 1'b0, 2'b00));
    @(negedge clk);
    chk("R9 pll to sub", clk_sel, 1);
    chk("R8 mult unchanged by pll-side write", mult_code, 3);
    go_main();
  endtask

  task automatic t_cancel();
    do_write(img(2'b01, 1'b1, 1'b0, 2'b00));
    repeat (20) @(negedge clk);
    chk("R9 busy before cancel", busy, 1);
    do_write(img(2'b01, 1'b1, 1'b1, 2'b00));
    @(negedge clk);
    chk("R9 busy dropped", busy, 0);
    chk("R9 cancel to main", clk_sel, 0);
    chk("R9 status after cancel", rd_data[15:14], 2'b11);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    rst_n    = 1'b0;
    por_rst  = 1'b1;
    wr_en    = 1'b0;
    wr_data  = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    por_rst = 1'b0;
    t_readonly();
    t_sub_priority();
    t_wait(2'b00, 1'b0, 1024,  "R6 wait code 00");
    t_wait(2'b01, 1'b0, 8192,  "R6 wait code 01");
    t_wait(2'b10, 1'b0, 16384, "R6 wait code 10");
    t_wait(2'b11, 1'b0, 32768, "R7 wait code 11 other reset");
    t_wait(2'b11, 1'b1, 65536, "R7 wait code 11 power-on");
    t_mult_lock();
    t_cancel();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cycles = 0;
    while (cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=<190000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule